// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets logic running on one clock read and write an external asynchronous static RAM of 128K bytes. The RAM has two chip enables of opposite polarity, an output enable and a write enable, all driven from registers so that each strobe moves only on a clock edge. The host offers one request at a time on a valid/ready port. A request carries a 17-bit address, a write flag and a byte of write data. A read returns its byte with a single-cycle valid pulse.

Every phase length is a count of clock cycles. The count is worked out when the block is built, from timing parameters given in nanoseconds and from the clock period, by rounding up. No phase is shorter than one cycle. A write uses three phases. In the first, the address and enables are set up. In the second, the write strobe is low and the data bus is driven. In the third, the strobe has gone high but the data and enables are still held. A read holds the output enable low for the access time and captures the bus on the last cycle of that count. After a read, the block waits out a turnaround period with both enables released. The RAM stays deselected whenever no access is in progress, so it sits in its low-power standby state.

A request is accepted only when the block is idle and the minimum cycle time of the previous access has passed since that access was accepted.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the RAM is deselected with every strobe inactive: `mem_sel_n`=1, `mem_sel`=0, `mem_oe_n`=1, `mem_we_n`=1.
- R2: The two chip enables always carry opposite levels (`mem_sel_n` = NOT `mem_sel`), so both select or both deselect together.
- R3: Read timing. After a read is accepted, `mem_oe_n` is low with the RAM selected and `mem_we_n` high for ceil(T_AA_NS/CLK_NS) cycles. The byte on `mem_dq` in the last of those cycles appears on `rsp_rdata`. In the same edge, `rsp_valid` rises for exactly one cycle.
- R4: Turnaround after a read. In the cycle in which `rsp_valid` is high, the RAM is already deselected with `mem_oe_n` high. It stays that way for ceil(T_HZ_NS/CLK_NS) cycles before the block returns to idle. A read is therefore followed by the next acceptance no sooner than N_ACC + N_HZ + 1 cycles later, and `mem_we_n` never falls within T_HZ_NS of a rise of `mem_oe_n`.
- R5: Write sequence. After a write is accepted, the RAM is selected with `mem_we_n` high for N_SETUP = ceil((T_AW_NS−T_PWE_NS)/CLK_NS) cycles, with a minimum of 1. Next, `mem_we_n` is low for N_PULSE = ceil(max(T_PWE_NS,T_SD_NS)/CLK_NS) cycles while `mem_dq` carries the write data. Then `mem_we_n` is high for one cycle with the data and enables still held. After that the RAM is deselected.
- R6: At each rising edge of `mem_we_n` that ends a write, the following hold. The strobe has been low for at least T_PWE_NS. The data has been stable for at least T_SD_NS. The address has been stable for at least T_AW_NS. The address does not change while `mem_we_n` is low.
- R7: `mem_oe_n` stays high throughout a write, and `mem_we_n` and `mem_oe_n` are never low at the same time, so the RAM and the block never drive `mem_dq` together.
- R8: A byte written to an address is returned by a later read of that address, including address 0x00000, address 0x1FFFF, and the data values 0x00 and 0xFF.
- R9: After a write is accepted, no other request is accepted for max(ceil(T_WC_NS/CLK_NS), N_SETUP+N_PULSE+2) cycles. The same bound with ceil(T_RC_NS/CLK_NS) applies after a read. A request held valid meanwhile is taken on the first cycle allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block takes the request on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_addr | output | 17 | Address to the RAM |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq | inout | 8 | Bidirectional data bus |

## Verification
The bench builds the block with a 5 ns clock and a write pulse of 38 ns. Because 38 is not a multiple of 5, the pulse count of 8 and the setup count of 3 both come from rounding up. The write cycle time is stretched to 100 ns, so the spacing limit (20 cycles) is longer than the write sequence itself (13 cycles) and becomes what the bench sees between writes. The read cycle time is kept at 55 ns. Read spacing is therefore set by the access and turnaround phases (16 cycles), and the two limits are observed separately. A behavioural RAM model answers reads only 50 ns after its inputs settle. The model also times every write-ending edge and checks for bus contention.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPUL,
        ST_WEND,
        ST_RACC,
        ST_RTURN
    } asram_state_e;

    // Round a nanosecond window up to whole clock cycles, at least one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        if (ns <= 0) return 1;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_io_pad.sv
`timescale 1ns/1ps
module asram_io_pad #(
    parameter int W = 8
) (
    inout  wire  [W-1:0] pad,
    input  logic         drive,
    input  logic [W-1:0] dout,
    output logic [W-1:0] din
);
    assign pad = drive ? dout : {W{1'bz}};
    assign din = pad;
endmodule

// File: rtl/asram_gap_timer.sv
`timescale 1ns/1ps
module asram_gap_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 5,
    parameter int T_WC_NS  = 55,
    parameter int T_RC_NS  = 55,
    parameter int T_PWE_NS = 40,
    parameter int T_AW_NS  = 50,
    parameter int T_SD_NS  = 25,
    parameter int T_AA_NS  = 55,
    parameter int T_HZ_NS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int N_SETUP = ns_to_cyc(T_AW_NS - T_PWE_NS, CLK_NS);
    localparam int N_PULSE = ns_to_cyc(max2(T_PWE_NS, T_SD_NS), CLK_NS);
    localparam int N_ACC   = ns_to_cyc(T_AA_NS, CLK_NS);
    localparam int N_HZ    = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int N_WC    = max2(ns_to_cyc(T_WC_NS, CLK_NS), N_SETUP + N_PULSE + 2);
    localparam int N_RC    = max2(ns_to_cyc(T_RC_NS, CLK_NS), N_ACC + N_HZ + 1);
    localparam int N_PH    = max2(max2(N_SETUP, N_PULSE), max2(N_ACC, N_HZ));
    localparam int CNT_W   = $clog2(N_PH + 1);
    localparam int GAP_W   = $clog2(max2(N_WC, N_RC) + 1);

    typedef struct packed {
        asram_state_e      st;
        logic [CNT_W-1:0]  cnt;
        logic              sel;
        logic              oe;
        logic              we;
        logic              drv;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              gap_done;
    logic              accept;
    logic [GAP_W-1:0]  gap_load;
    logic [DATA_W-1:0] dq_in;

    assign req_ready = (ctl_q.st == ST_IDLE) && gap_done;
    assign accept    = req_valid && req_ready;
    assign gap_load  = req_write ? GAP_W'(N_WC - 1) : GAP_W'(N_RC - 1);

    asram_gap_timer #(.W(GAP_W)) gap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .load_val (gap_load),
        .done     (gap_done)
    );

    asram_io_pad #(.W(DATA_W)) pad_i (
        .pad  (mem_dq),
        .drive(ctl_q.drv),
        .dout (ctl_q.wdata),
        .din  (dq_in)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.addr = req_addr;
                    ctl_d.sel  = 1'b1;
                    if (req_write) begin
                        ctl_d.st    = ST_WSET;
                        ctl_d.cnt   = CNT_W'(N_SETUP - 1);
                        ctl_d.wdata = req_wdata;
                    end else begin
                        ctl_d.st  = ST_RACC;
                        ctl_d.cnt = CNT_W'(N_ACC - 1);
                        ctl_d.oe  = 1'b1;
                    end
                end
            end
            ST_WSET: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st  = ST_WPUL;
                    ctl_d.cnt = CNT_W'(N_PULSE - 1);
                    ctl_d.we  = 1'b1;
                    ctl_d.drv = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_WPUL: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st = ST_WEND;
                    ctl_d.we = 1'b0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_WEND: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.sel = 1'b0;
                ctl_d.drv = 1'b0;
            end
            ST_RACC: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st     = ST_RTURN;
                    ctl_d.cnt    = CNT_W'(N_HZ - 1);
                    ctl_d.rdata  = dq_in;
                    ctl_d.rvalid = 1'b1;
                    ctl_d.oe     = 1'b0;
                    ctl_d.sel    = 1'b0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_RTURN: begin
                if (ctl_q.cnt == '0)
                    ctl_d.st = ST_IDLE;
                else
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            default: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.sel = 1'b0;
                ctl_d.oe  = 1'b0;
                ctl_d.we  = 1'b0;
                ctl_d.drv = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_addr  = ctl_q.addr;
    assign mem_sel   = ctl_q.sel;
    assign mem_sel_n = ~ctl_q.sel;
    assign mem_oe_n  = ~ctl_q.oe;
    assign mem_we_n  = ~ctl_q.we;
    assign rsp_valid = ctl_q.rvalid;
    assign rsp_rdata = ctl_q.rdata;
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk
    import asram_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int CLK_NS   = 5,
    parameter int T_PWE_NS = 40,
    parameter int T_SD_NS  = 25,
    parameter int T_HZ_NS  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_oe_n,
    input logic              mem_we_n
);
    localparam int MIN_PW = ns_to_cyc(max2(T_PWE_NS, T_SD_NS), CLK_NS);
    localparam int MIN_HZ = ns_to_cyc(T_HZ_NS, CLK_NS);

    logic [7:0] lo_cnt_q;
    logic [7:0] oe_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt_q <= '0;
            oe_hi_q  <= 8'hFF;
        end else begin
            lo_cnt_q <= !mem_we_n ? ((lo_cnt_q == 8'hFF) ? lo_cnt_q : lo_cnt_q + 1'b1) : 8'h00;
            oe_hi_q  <= mem_oe_n ? ((oe_hi_q == 8'hFF) ? oe_hi_q : oe_hi_q + 1'b1) : 8'h00;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n));

    p_enable_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n != mem_sel);

    p_read_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_sel_n));

    p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_turnaround_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (oe_hi_q >= 8'(MIN_HZ)));

    p_write_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_sel_n && mem_sel));

    p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (lo_cnt_q >= 8'(MIN_PW)));

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> $stable(mem_addr));

    p_no_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);
endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .CLK_NS  (CLK_NS),
    .T_PWE_NS(T_PWE_NS),
    .T_SD_NS (T_SD_NS),
    .T_HZ_NS (T_HZ_NS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_sel_n(mem_sel_n),
    .mem_sel  (mem_sel),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;
    localparam int CLK = 5;
    localparam int PWE = 38;
    localparam int AW  = 50;
    localparam int SD  = 25;
    localparam int AA  = 55;
    localparam int HZ  = 20;
    localparam int WC  = 100;
    localparam int RC  = 55;
    // expected phase counts, rounded up by hand from the requirement formulas
    localparam int E_SETUP = (AW - PWE + CLK - 1) / CLK;
    localparam int E_PULSE = (PWE + CLK - 1) / CLK;
    localparam int E_ACC   = (AA + CLK - 1) / CLK;
    localparam int E_HZ    = (HZ + CLK - 1) / CLK;
    localparam int E_WGAP  = (WC + CLK - 1) / CLK;
    localparam int E_RGAP  = E_ACC + E_HZ + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    wire         req_ready, rsp_valid;
    wire  [7:0]  rsp_rdata;
    wire  [16:0] mem_addr;
    wire         mem_sel_n, mem_sel, mem_oe_n, mem_we_n;
    wire  [7:0]  mem_dq;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit pair_bad = 1'b0;
    bit have_prev = 1'b0;
    bit prev_wr = 1'b0;
    int prev_acc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    asram_ctrl #(
        .CLK_NS(CLK), .T_WC_NS(WC), .T_RC_NS(RC), .T_PWE_NS(PWE),
        .T_AW_NS(AW), .T_SD_NS(SD), .T_AA_NS(AA), .T_HZ_NS(HZ)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural RAM model ----------------
    logic [7:0] store [int];
    logic       mdl_en = 1'b0;
    logic [7:0] mdl_q = '0;
    realtime    t_rd_chg = 0, t_addr_chg = 0, t_dq_chg = 0, t_we_fall = 0, t_oe_rise = -1000;

    assign mem_dq = mdl_en ? mdl_q : 8'bz;

    function automatic logic [7:0] peek(input int a);
        return store.exists(a) ? store[a] : 8'h00;
    endfunction

    always @(mem_addr or mem_sel_n or mem_sel or mem_oe_n) t_rd_chg = $realtime;
    always @(mem_addr) t_addr_chg = $realtime;
    always @(mem_dq) t_dq_chg = $realtime;
    always @(posedge mem_oe_n) t_oe_rise = $realtime;

    initial begin
        forever begin
            #1;
            mdl_en = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;
            mdl_q  = (($realtime - t_rd_chg) >= 50.0) ? peek(int'(mem_addr)) : ~peek(int'(mem_addr));
        end
    end

    always @(negedge mem_we_n) begin
        if (rst_n) begin
            t_we_fall = $realtime;
            chk(mem_oe_n == 1'b1, "R7 oe_n high at write strobe", int'(mem_oe_n), 1);
            chk(($realtime - t_oe_rise) >= HZ, "R4 ns from oe_n rise to we_n fall",
                int'($realtime - t_oe_rise), HZ);
        end
    end

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_sel_n && mem_sel) begin
            chk(($realtime - t_we_fall) >= PWE, "R6 we_n low ns", int'($realtime - t_we_fall), PWE);
            chk(($realtime - t_dq_chg) >= SD, "R6 data setup ns", int'($realtime - t_dq_chg), SD);
            chk(($realtime - t_addr_chg) >= AW, "R6 address setup ns", int'($realtime - t_addr_chg), AW);
            store[int'(mem_addr)] = mem_dq;
        end
    end

    // R2: both enables always opposite
    always @(negedge clk) begin
        if (rst_n && (mem_sel_n == mem_sel) && !pair_bad) begin
            pair_bad = 1'b1;
            n_fail++;
            $display("FAIL R2 enable pair: actual %0d expected %0d", int'(mem_sel), int'(!mem_sel_n));
        end
    end

    // ---------------- tasks ----------------
    task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] dat);
        int acc;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat;
        while (!req_ready) @(negedge clk);
        acc = cyc;
        @(posedge clk);
        if (have_prev) begin
            if (prev_wr)
                chk(acc - prev_acc == E_WGAP, "R9 cycles between accepts after write", acc - prev_acc, E_WGAP);
            else
                chk(acc - prev_acc == E_RGAP, "R4 cycles between accepts after read", acc - prev_acc, E_RGAP);
        end
        have_prev = 1'b1; prev_wr = wr; prev_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n, "R1 strobes idle after reset",
            {mem_sel_n, mem_sel, mem_oe_n, mem_we_n}, 4'b1011);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R3 no response after reset", int'(rsp_valid), 0);
    endtask

    task automatic t_write(input logic [16:0] a, input logic [7:0] dat);
        int fall_i = -1, low_n = 0, oe_low = 0, sel_n_cnt = 0;
        bit dq_ok = 1'b1, sel_end = 1'b0, desel = 1'b0;
        issue(1'b1, a, dat);
        for (int i = 0; i <= E_SETUP + E_PULSE + 1; i++) begin
            if (i > 0) @(negedge clk);
            if (!mem_we_n) begin
                if (fall_i < 0) fall_i = i;
                low_n++;
                if (mem_dq != dat) dq_ok = 1'b0;
            end
            if (!mem_oe_n) oe_low++;
            if (i <= E_SETUP + E_PULSE && !mem_sel_n) sel_n_cnt++;
            if (i == E_SETUP + E_PULSE) sel_end = !mem_sel_n && mem_sel && mem_we_n && (mem_dq == dat);
            if (i == E_SETUP + E_PULSE + 1) desel = mem_sel_n && !mem_sel;
        end
        chk(fall_i == E_SETUP, "R5 cycles before we_n falls", fall_i, E_SETUP);
        chk(low_n == E_PULSE, "R5 we_n low cycles", low_n, E_PULSE);
        chk(dq_ok, "R5 data on bus during strobe", int'(dq_ok), 1);
        chk(sel_n_cnt == E_SETUP + E_PULSE + 1, "R5 selected cycles", sel_n_cnt, E_SETUP + E_PULSE + 1);
        chk(sel_end, "R5 hold cycle after strobe", int'(sel_end), 1);
        chk(desel, "R1 deselected after write", int'(desel), 1);
        chk(oe_low == 0, "R7 oe_n low during write", oe_low, 0);
    endtask

    task automatic t_read(input logic [16:0] a, input logic [7:0] exp);
        int oe_low = 0, rv_n = 0, rv_i = -1;
        logic [7:0] got = '0;
        bit quiet = 1'b0;
        issue(1'b0, a, 8'h00);
        for (int i = 0; i <= E_ACC + 1; i++) begin
            if (i > 0) @(negedge clk);
            if (!mem_oe_n && !mem_sel_n && mem_we_n) oe_low++;
            if (rsp_valid) begin
                rv_n++;
                if (rv_i < 0) begin rv_i = i; got = rsp_rdata; end
            end
            if (i == E_ACC) quiet = mem_sel_n && mem_oe_n;
        end
        chk(oe_low == E_ACC, "R3 oe_n low cycles", oe_low, E_ACC);
        chk(rv_i == E_ACC, "R3 cycle of rsp_valid", rv_i, E_ACC);
        chk(rv_n == 1, "R3 rsp_valid pulse length", rv_n, 1);
        chk(got == exp, "R8 read data", int'(got), int'(exp));
        chk(quiet, "R4 released when data returned", int'(quiet), 1);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_write(17'h00000, 8'h3C);
        t_write(17'h1FFFF, 8'hFF);
        t_write(17'h0A5A5, 8'h00);
        t_read(17'h00000, 8'h3C);
        t_read(17'h1FFFF, 8'hFF);
        t_write(17'h0A5A5, 8'h5A);
        t_read(17'h0A5A5, 8'h5A);
        t_read(17'h00001, 8'h00);
        t_write(17'h00001, 8'hC3);
        t_read(17'h00001, 8'hC3);
        repeat (25) @(negedge clk);
        chk(req_ready && mem_sel_n && mem_oe_n && mem_we_n, "R1 idle after traffic",
            {req_ready, mem_sel_n, mem_oe_n, mem_we_n}, 4'b1111);
        n_run++;   // the R2 enable-pair monitor counts as one check
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule